// File: doc/BRIEF.md
# Redundant Converter Sample Comparator with Failover

This block sits behind two converter channels that sample the same signal at the same instant from a shared timing reference. Each clock it may receive one sample from the primary channel and one from the backup channel, each marked by its own valid strobe. When both strobes arrive together, the pair is one conversion moment. The block checks the two codes against each other and forwards one of them as the output sample.

If the two codes differ by more than a programmable limit for a programmable number of pairs in a row, the block counts the fault as confirmed. It then moves the output to the other channel. Both channels run all the time, so the move only changes which code is forwarded. It takes effect from the next pair and never splits an output sample. The block cannot tell on its own which channel has failed. It therefore marks the channel it leaves, sets a sticky fault flag and waits for software to clear it.

Each channel can be taken out for calibration. A channel under calibration is left out of the comparison and is never selected for the output. The other channel keeps the output stream running. A strobe that arrives on one channel only is reported as a loss of synchronisation.

Top module: `paired_sample_failover`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid, activeBak, faultSticky, noHealthy and syncLoss are 0. activeBak=0 selects the primary channel and activeBak=1 selects the backup channel.
- R2: When priValid and bakValid are both 1 in a cycle and at least one channel is not in calibration, outValid is 1 in the next cycle. In that cycle outData holds the selected channel's code from that pair. In every other cycle outValid is 0 and outData keeps its last value.
- R3: A pair mismatches only when the absolute difference of the two unsigned codes is strictly greater than mismatchLimit. A difference equal to the limit is agreement.
- R4: A fault is confirmed on the Nth consecutive mismatching pair, where N is persistLimit and a value of 0 counts as 1. An agreeing pair resets the count. A cycle without a valid pair neither counts nor resets.
- R5: On a confirmed fault where the other channel is not marked bad, activeBak toggles, the channel left behind is marked bad and faultSticky becomes 1, all visible in the next cycle. The confirming pair itself is output from the old channel.
- R6: If exactly one channel is in calibration during a valid pair, the pair is output from the other channel whatever activeBak is. No comparison takes place and the mismatch count resets to 0.
- R7: If both channels are in calibration during a valid pair, no output sample is produced and outValid stays 0.
- R8: On a confirmed fault where the other channel is already marked bad, activeBak holds and noHealthy becomes 1 and stays 1 until it is cleared.
- R9: faultClear=1 clears faultSticky, noHealthy, both bad marks and the mismatch count in the next cycle. It leaves activeBak unchanged and wins over a fault confirmed in the same cycle.
- R10: syncLoss is 1 for exactly the cycle after a cycle in which exactly one of priValid and bakValid was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| priData | input | SAMPLE_W | Primary channel code |
| priValid | input | 1 | Primary code strobe |
| bakData | input | SAMPLE_W | Backup channel code |
| bakValid | input | 1 | Backup code strobe |
| priCal | input | 1 | Primary channel under calibration |
| bakCal | input | 1 | Backup channel under calibration |
| mismatchLimit | input | SAMPLE_W | Largest difference still counted as agreement |
| persistLimit | input | PERSIST_W | Consecutive mismatches needed to confirm a fault |
| faultClear | input | 1 | Clears the fault state |
| outData | output | SAMPLE_W | Selected sample |
| outValid | output | 1 | Output sample strobe |
| activeBak | output | 1 | 1 when the backup channel is the active channel |
| faultSticky | output | 1 | A fault has been confirmed since the last clear |
| noHealthy | output | 1 | A fault was confirmed with no healthy channel left to move to |
| syncLoss | output | 1 | One-cycle pulse after a lone strobe |

## Verification
The stimulus places the code difference at exactly the limit and at one above it. A design that compares with greater-or-equal would raise faults on healthy pairs. Mismatch runs are broken both by agreeing pairs and by idle cycles, to catch a counter that resets on idle cycles or never resets. After a switchover, distinct codes on the two channels show whether the confirming pair came from the old channel and the following pair from the new one. Calibration is applied on the active channel, on the standby channel and on both, and a clear is issued in the same cycle as a confirming pair. A wrong selection, a count that keeps going during calibration, or a clear that loses to the fault then shows up as a wrong output code or wrong flags.

// File: rtl/psf_pkg.sv
package psf_pkg;
  // Strobes from control to datapath for one output sample.
  typedef struct packed {
    logic loadOut;  // capture a sample this cycle
    logic selBak;   // take the backup code instead of the primary
  } psfCtrl_t;
endpackage

// File: rtl/psf_datapath.sv
module psf_datapath
  import psf_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] priData,
  input  logic [SAMPLE_W-1:0] bakData,
  input  logic [SAMPLE_W-1:0] mismatchLimit,
  input  psfCtrl_t            ctrl,
  output logic                mismatch,
  output logic [SAMPLE_W-1:0] outData
);
  logic [SAMPLE_W-1:0] absDiff;

  always_comb begin
    if (priData >= bakData) absDiff = priData - bakData;
    else                    absDiff = bakData - priData;
    mismatch = absDiff > mismatchLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outData <= '0;
    else if (ctrl.loadOut) outData <= ctrl.selBak ? bakData : priData;
  end

  // R2: without a load the output code must hold
  assert_hold_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadOut |=> $stable(outData));
endmodule

// File: rtl/psf_control.sv
module psf_control
  import psf_pkg::*;
#(
  parameter int PERSIST_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 priValid,
  input  logic                 bakValid,
  input  logic                 priCal,
  input  logic                 bakCal,
  input  logic                 mismatch,
  input  logic [PERSIST_W-1:0] persistLimit,
  input  logic                 faultClear,
  output psfCtrl_t             ctrl,
  output logic                 outValid,
  output logic                 activeBak,
  output logic                 faultSticky,
  output logic                 noHealthy,
  output logic                 syncLoss
);
  logic                 pairValid;
  logic                 compareOk;
  logic                 confirm;
  logic [PERSIST_W-1:0] missCnt;
  logic [PERSIST_W-1:0] cntNext;
  logic [PERSIST_W-1:0] limitEff;
  logic [1:0]           chanBad;  // index 0 primary, 1 backup

  always_comb begin
    pairValid    = priValid & bakValid;
    compareOk    = pairValid & ~priCal & ~bakCal;
    limitEff     = (persistLimit == '0) ? PERSIST_W'(1) : persistLimit;
    cntNext      = missCnt + PERSIST_W'(1);
    confirm      = compareOk & mismatch & (cntNext >= limitEff);
    ctrl.loadOut = pairValid & ~(priCal & bakCal);
    ctrl.selBak  = priCal | (~bakCal & activeBak);
  end

  assign faultSticky = |chanBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      syncLoss  <= 1'b0;
      activeBak <= 1'b0;
      missCnt   <= '0;
      chanBad   <= 2'b00;
      noHealthy <= 1'b0;
    end else begin
      outValid <= ctrl.loadOut;
      syncLoss <= priValid ^ bakValid;
      if (faultClear) begin
        missCnt   <= '0;
        chanBad   <= 2'b00;
        noHealthy <= 1'b0;
      end else if (compareOk) begin
        if (!mismatch) begin
          missCnt <= '0;
        end else if (confirm) begin
          missCnt <= '0;
          if (chanBad[~activeBak]) begin
            noHealthy <= 1'b1;
          end else begin
            chanBad[activeBak] <= 1'b1;
            activeBak          <= ~activeBak;
          end
        end else begin
          missCnt <= cntNext;
        end
      end else if (pairValid) begin
        missCnt <= '0;
      end
    end
  end

  // R2: a sample leaves only for a coincident pair
  assert_valid_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(priValid & bakValid));
  // R5: the active channel moves only after a mismatching compared pair
  assert_switch_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (activeBak != $past(activeBak)) |-> $past(compareOk & mismatch & ~faultClear));
  // R6: a channel under calibration is never the selected one
  assert_cal_excluded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadOut & priCal) |-> ctrl.selBak);
  // R8: alarm persists until cleared
  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (noHealthy & ~faultClear) |=> noHealthy);
  // R10: sync loss reports a lone strobe
  assert_sync_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    syncLoss |-> $past(priValid != bakValid));
endmodule

// File: rtl/paired_sample_failover.sv
module paired_sample_failover
  import psf_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int PERSIST_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SAMPLE_W-1:0]  priData,
  input  logic                 priValid,
  input  logic [SAMPLE_W-1:0]  bakData,
  input  logic                 bakValid,
  input  logic                 priCal,
  input  logic                 bakCal,
  input  logic [SAMPLE_W-1:0]  mismatchLimit,
  input  logic [PERSIST_W-1:0] persistLimit,
  input  logic                 faultClear,
  output logic [SAMPLE_W-1:0]  outData,
  output logic                 outValid,
  output logic                 activeBak,
  output logic                 faultSticky,
  output logic                 noHealthy,
  output logic                 syncLoss
);
  psfCtrl_t ctrl;
  logic     mismatch;

  psf_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .priData(priData), .bakData(bakData),
    .mismatchLimit(mismatchLimit), .ctrl(ctrl), .mismatch(mismatch),
    .outData(outData)
  );

  psf_control #(.PERSIST_W(PERSIST_W)) u_ctl (
    .clk(clk), .rstN(rstN), .priValid(priValid), .bakValid(bakValid),
    .priCal(priCal), .bakCal(bakCal), .mismatch(mismatch),
    .persistLimit(persistLimit), .faultClear(faultClear), .ctrl(ctrl),
    .outValid(outValid), .activeBak(activeBak), .faultSticky(faultSticky),
    .noHealthy(noHealthy), .syncLoss(syncLoss)
  );
endmodule

// File: tb/paired_sample_failover_tb.sv
`timescale 1ns/1ps
module paired_sample_failover_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] priData = '0, bakData = '0, mismatchLimit = 12'd4;
  logic        priValid = 0, bakValid = 0, priCal = 0, bakCal = 0, faultClear = 0;
  logic [3:0]  persistLimit = 4'd3;
  logic [11:0] outData;
  logic        outValid, activeBak, faultSticky, noHealthy, syncLoss;

  int errors = 0, checks = 0;
  // reference state
  int mCnt = 0, mAct = 0, mOutData = 0;
  bit mBad[2] = '{0, 0};
  bit mAlarm = 0, mOutValid = 0, mSync = 0;

  always #2.5 clk = ~clk;

  paired_sample_failover u_dut (
    .clk(clk), .rstN(rstN), .priData(priData), .priValid(priValid),
    .bakData(bakData), .bakValid(bakValid), .priCal(priCal), .bakCal(bakCal),
    .mismatchLimit(mismatchLimit), .persistLimit(persistLimit),
    .faultClear(faultClear), .outData(outData), .outValid(outValid),
    .activeBak(activeBak), .faultSticky(faultSticky), .noHealthy(noHealthy),
    .syncLoss(syncLoss)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int d, lim;
    mSync = priValid != bakValid;
    mOutValid = priValid && bakValid && !(priCal && bakCal);
    if (mOutValid) begin
      if (priCal)      mOutData = bakData;
      else if (bakCal) mOutData = priData;
      else             mOutData = mAct ? bakData : priData;
    end
    d = int'(priData) - int'(bakData);
    if (d < 0) d = -d;
    lim = (persistLimit == 0) ? 1 : persistLimit;
    if (faultClear) begin
      mCnt = 0; mBad[0] = 0; mBad[1] = 0; mAlarm = 0;
    end else if (priValid && bakValid) begin
      if (priCal || bakCal) mCnt = 0;
      else if (d > mismatchLimit) begin
        mCnt++;
        if (mCnt >= lim) begin
          mCnt = 0;
          if (mBad[1 - mAct]) mAlarm = 1;
          else begin mBad[mAct] = 1; mAct = 1 - mAct; end
        end
      end else mCnt = 0;
    end
  endtask

  task automatic compareAll(string tag);
    chk({tag, " outValid"}, outValid, mOutValid);
    chk({tag, " outData"}, outData, mOutData);
    chk({tag, " activeBak"}, activeBak, mAct);
    chk({tag, " faultSticky"}, faultSticky, mBad[0] | mBad[1]);
    chk({tag, " noHealthy"}, noHealthy, mAlarm);
    chk({tag, " syncLoss"}, syncLoss, mSync);
  endtask

  // drive one cycle at negedge, advance, compare at next negedge
  task automatic cyc(string tag, bit pv, bit bv, int pd, int bd,
                     bit pc = 0, bit bc = 0, bit clr = 0);
    priValid = pv; bakValid = bv; priData = 12'(pd); bakData = 12'(bd);
    priCal = pc; bakCal = bc; faultClear = clr;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R2/R3: agreement at exactly the limit, primary forwarded
    for (int i = 0; i < 6; i++) cyc("R3 equal limit", 1, 1, 200 + i, 204 + i);
    for (int i = 0; i < 3; i++) cyc("R2 idle", 0, 0, 7, 9);

    // R4: mismatch runs broken by agreement; idle cycles neither count nor reset
    cyc("R4 miss1", 1, 1, 300, 305);
    cyc("R4 idle", 0, 0, 0, 0);
    cyc("R4 miss2", 1, 1, 301, 306);
    cyc("R4 agree", 1, 1, 302, 303);
    cyc("R4 miss1b", 1, 1, 310, 320);
    cyc("R4 miss2b", 1, 1, 311, 321);
    cyc("R4 agree b", 1, 1, 312, 312);
    // R5: three consecutive mismatches with an idle gap
    cyc("R5 m1", 1, 1, 400, 450);
    cyc("R5 m2", 1, 1, 401, 451);
    cyc("R5 idle", 0, 0, 0, 0);
    cyc("R5 confirm old channel", 1, 1, 402, 452);
    chk("R5 switched", activeBak, 1);
    cyc("R5 new channel", 1, 1, 403, 453);
    chk("R5 backup code", outData, 453);

    // R6: calibration on the active (backup) and on the standby channel
    for (int i = 0; i < 3; i++) cyc("R6 bak cal", 1, 1, 500 + i, 900 + i, 0, 1);
    chk("R6 primary served", outData, 502);
    cyc("R6 m1", 1, 1, 510, 600);
    cyc("R6 m2", 1, 1, 511, 601);
    cyc("R6 pri cal resets", 1, 1, 512, 602, 1, 0);
    cyc("R6 m1 again", 1, 1, 513, 603);
    cyc("R6 m2 again", 1, 1, 514, 604);
    chk("R6 no alarm yet", noHealthy, 0);

    // R7: both in calibration
    cyc("R7 both cal", 1, 1, 700, 701, 1, 1);
    chk("R7 no output", outValid, 0);

    // R8: primary already bad -> hold and alarm
    cyc("R8 m1", 1, 1, 800, 850);
    cyc("R8 m2", 1, 1, 801, 851);
    cyc("R8 m3", 1, 1, 802, 852);
    chk("R8 alarm", noHealthy, 1);
    chk("R8 held", activeBak, 1);
    for (int i = 0; i < 3; i++) cyc("R8 sticky", 1, 1, 810 + i, 811 + i);

    // R9: clear keeps channel; clear beats a same-cycle confirmation
    cyc("R9 clear", 0, 0, 0, 0, 0, 0, 1);
    chk("R9 cleared", faultSticky, 0);
    cyc("R9 m1", 1, 1, 100, 140);
    cyc("R9 m2", 1, 1, 101, 141);
    cyc("R9 confirm with clear", 1, 1, 102, 142, 0, 0, 1);
    chk("R9 clear wins", activeBak, 1);
    cyc("R9 m1 again", 1, 1, 103, 143);
    cyc("R9 m2 again", 1, 1, 104, 144);
    cyc("R9 m3 again", 1, 1, 105, 145);
    chk("R9 back to primary", activeBak, 0);

    // R10: lone strobes
    cyc("R10 pri only", 1, 0, 20, 20);
    cyc("R10 pulse end", 0, 0, 0, 0);
    cyc("R10 bak only", 0, 1, 20, 20);
    cyc("R10 pair", 1, 1, 21, 21);

    // R4: persistLimit 0 behaves as 1
    cyc("R4 clear", 0, 0, 0, 0, 0, 0, 1);
    persistLimit = 4'd0;
    cyc("R4 limit0 confirm", 1, 1, 1000, 4000);
    chk("R4 limit0 switched", activeBak, 1);
    cyc("R4 limit0 after", 1, 1, 1001, 4001);
    chk("R4 limit0 code", outData, 4001);

    summary();
  end
endmodule